// File: doc/BRIEF.md
# Key Vault with Attested Zeroization

This block keeps a session key beside a crypto engine. A requester writes a key and a session identifier through a provisioning handshake. The block holds both in dedicated transient registers. While the session is live, the engine reads the key through a read port. The read port shows zero at every other time.

Zeroization starts when the engine raises its completion flag or when a command strobe arrives. The block then clears the key registers. Next it takes a snapshot of the cache-line slots tagged as holding key data. It visits the slots one by one in ascending order and sends each tagged slot a request that invalidates the line without writeback. It waits for an acknowledge on each request before it moves on. After the sweep it reads the key registers back to confirm they are zero. It latches a timestamp from a free-running cycle counter.

It then offers a deletion record on a valid/ready bus. The record carries the session identifier, a status code and the timestamp. A fixed root-key slot number travels with the record to an external signer. Control returns, and a new key can be provisioned, only once that record has been accepted.

Top module: `key_vault_zeroizer`

## Requirements
- R1: After reset, prov_ready_o=1, busy_o=0, key_live_o=0, key_rd_o=0, inv_req_o=0, rec_valid_o=0 and done_o=0.
- R2: A key and identifier are taken at a clock edge where prov_valid_i and prov_ready_o are both high. From the next cycle key_live_o=1 and key_rd_o shows the key.
- R3: key_rd_o is all zeros in every cycle where key_live_o is low.
- R4: done_flag_i or zero_cmd_i starts zeroization only while a key is live. In the idle state either strobe leaves busy_o, rec_valid_o and prov_ready_o unchanged.
- R5: prov_ready_o is low from the moment a key is loaded until its record is accepted. busy_o is high from the cycle after the trigger until the record is accepted. A provisioning attempt in that window changes neither the live key nor the identifier in the record.
- R6: The tag mask is sampled at the trigger edge. Each tagged slot gets exactly one request, in ascending slot order. inv_req_o and inv_slot_o hold until inv_ack_i, and inv_nowb_o is high with every request.
- R7: The time from the trigger edge to the first cycle of rec_valid_o is 3 + N_SLOTS cycles plus, for each tagged slot, the number of cycles its request waited before being acknowledged.
- R8: rec_valid_o rises only after every tagged slot has been acknowledged. No invalidation request is raised while the record is offered.
- R9: rec_o = {session id, status[7:0], timestamp[31:0]}, with the identifier in the top bits. The status is 8'hA5 when the key registers read back as zero and 8'h5A otherwise. The timestamp is the free-running counter value latched at the edge that ends verification. That counter is 0 at the first edge after reset and rises by one at each edge.
- R10: rec_o and rec_valid_o hold until rec_ready_i. done_o is high exactly in the handshake cycle. In the next cycle the block is idle again: prov_ready_o=1, busy_o=0, rec_valid_o=0.
- R11: sign_slot_o always equals the ROOT_SLOT parameter (default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prov_valid_i | input | 1 | Provisioning request |
| prov_key_i | input | KEY_W | Session key to load |
| prov_sid_i | input | SID_W | Session identifier to load |
| prov_ready_o | output | 1 | Vault can accept a key |
| busy_o | output | 1 | Zeroization in progress |
| key_live_o | output | 1 | Key is live and readable |
| key_rd_o | output | KEY_W | Key read port, zero unless live |
| done_flag_i | input | 1 | Engine completion flag |
| zero_cmd_i | input | 1 | Explicit zeroize command strobe |
| slot_tag_i | input | N_SLOTS | Slots currently holding key data |
| inv_req_o | output | 1 | Invalidate request |
| inv_slot_o | output | IDX_W | Slot index of the request |
| inv_nowb_o | output | 1 | Drop line without writeback |
| inv_ack_i | input | 1 | Invalidate acknowledged |
| rec_valid_o | output | 1 | Deletion record offered |
| rec_ready_i | input | 1 | Deletion record taken |
| rec_o | output | SID_W+40 | {sid, status, timestamp} |
| sign_slot_o | output | 4 | Root-key slot for the signer |
| done_o | output | 1 | Zeroize complete, control returned |

## Verification
A stuck or skipped state in the sweep shows at the ports within one slot time. It appears as a request for the wrong slot, a missing or repeated request, or a record that appears early; the latency check in R7 catches the last of these to the cycle. A key register that fails to clear shows up as status 8'h5A in the next record. A read-port gate that leaks shows as nonzero key_rd_o in the cycle right after the trigger. A premature return to idle shows as prov_ready_o or done_o high while a record is still pending.

// File: rtl/kv_pkg.sv
package kv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOADED, ST_ZREGS, ST_INVAL, ST_VERIFY, ST_REPORT
  } kv_state_e;

  localparam int STAT_W = 8;
  localparam int TS_W   = 32;
  localparam logic [STAT_W-1:0] STAT_OK  = 8'hA5;
  localparam logic [STAT_W-1:0] STAT_BAD = 8'h5A;
endpackage

// File: rtl/kv_ctrl.sv
module kv_ctrl
  import kv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      prov_fire_i,
  input  logic      trig_i,
  input  logic      sweep_done_i,
  input  logic      rec_fire_i,
  output kv_state_e state_o
);
  kv_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (prov_fire_i)  st_d = ST_LOADED;
      ST_LOADED: if (trig_i)       st_d = ST_ZREGS;
      ST_ZREGS:                    st_d = ST_INVAL;
      ST_INVAL:  if (sweep_done_i) st_d = ST_VERIFY;
      ST_VERIFY:                   st_d = ST_REPORT;
      ST_REPORT: if (rec_fire_i)   st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/kv_key_store.sv
module kv_key_store #(
  parameter int KEY_W = 128,
  parameter int SID_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [SID_W-1:0] sid_i,
  input  logic             clear_key_i,
  input  logic             clear_sid_i,
  input  logic             live_i,
  output logic [KEY_W-1:0] key_rd_o,
  output logic [SID_W-1:0] sid_o,
  output logic             all_zero_o
);
  logic [KEY_W-1:0] key_q;
  logic [SID_W-1:0] sid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      sid_q <= '0;
    end else begin
      if (load_i)           key_q <= key_i;
      else if (clear_key_i) key_q <= '0;
      if (load_i)           sid_q <= sid_i;
      else if (clear_sid_i) sid_q <= '0;
    end
  end

  // gate read port: nothing visible outside the live window
  assign key_rd_o   = live_i ? key_q : '0;
  assign sid_o      = sid_q;
  assign all_zero_o = (key_q == '0);
endmodule

// File: rtl/kv_line_sweep.sv
module kv_line_sweep #(
  parameter int N_SLOTS = 4,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  input  logic [N_SLOTS-1:0] tag_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   slot_o,
  output logic               done_o
);
  logic [N_SLOTS-1:0] mask_q;
  logic [IDX_W-1:0]   idx_q;
  logic               cur_tag;
  logic               step;
  logic               last;

  assign cur_tag = mask_q[idx_q];
  assign req_o   = run_i & cur_tag;
  assign step    = run_i & (~cur_tag | ack_i);
  assign last    = (idx_q == IDX_W'(N_SLOTS - 1));
  assign done_o  = step & last;
  assign slot_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      mask_q <= tag_i;
      idx_q  <= '0;
    end else if (step) begin
      if (last) begin
        idx_q  <= '0;
        mask_q <= '0;
      end else begin
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/kv_cycle_ctr.sv
module kv_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/key_vault_zeroizer.sv
module key_vault_zeroizer
  import kv_pkg::*;
#(
  parameter int          KEY_W     = 128,
  parameter int          SID_W     = 16,
  parameter int          N_SLOTS   = 4,
  parameter logic [3:0]  ROOT_SLOT = 4'd3,
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int REC_W = SID_W + STAT_W + TS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prov_valid_i,
  input  logic [KEY_W-1:0]   prov_key_i,
  input  logic [SID_W-1:0]   prov_sid_i,
  output logic               prov_ready_o,
  output logic               busy_o,
  output logic               key_live_o,
  output logic [KEY_W-1:0]   key_rd_o,
  input  logic               done_flag_i,
  input  logic               zero_cmd_i,
  input  logic [N_SLOTS-1:0] slot_tag_i,
  output logic               inv_req_o,
  output logic [IDX_W-1:0]   inv_slot_o,
  output logic               inv_nowb_o,
  input  logic               inv_ack_i,
  output logic               rec_valid_o,
  input  logic               rec_ready_i,
  output logic [REC_W-1:0]   rec_o,
  output logic [3:0]         sign_slot_o,
  output logic               done_o
);
  kv_state_e          st;
  logic               prov_fire, trig, sweep_done, rec_fire;
  logic               all_zero;
  logic [SID_W-1:0]   sid;
  logic [TS_W-1:0]    cnt, ts_q;
  logic [STAT_W-1:0]  stat_q;

  assign prov_fire = prov_valid_i & (st == ST_IDLE);
  assign trig      = (st == ST_LOADED) & (done_flag_i | zero_cmd_i);
  assign rec_fire  = (st == ST_REPORT) & rec_ready_i;

  kv_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .prov_fire_i (prov_fire),
    .trig_i      (trig),
    .sweep_done_i(sweep_done),
    .rec_fire_i  (rec_fire),
    .state_o     (st)
  );

  kv_key_store #(.KEY_W(KEY_W), .SID_W(SID_W)) u_store (
    .clk_i, .rst_ni,
    .load_i     (prov_fire),
    .key_i      (prov_key_i),
    .sid_i      (prov_sid_i),
    .clear_key_i(st == ST_ZREGS),
    .clear_sid_i(rec_fire),
    .live_i     (st == ST_LOADED),
    .key_rd_o   (key_rd_o),
    .sid_o      (sid),
    .all_zero_o (all_zero)
  );

  kv_line_sweep #(.N_SLOTS(N_SLOTS)) u_sweep (
    .clk_i, .rst_ni,
    .start_i(trig),
    .run_i  (st == ST_INVAL),
    .tag_i  (slot_tag_i),
    .ack_i  (inv_ack_i),
    .req_o  (inv_req_o),
    .slot_o (inv_slot_o),
    .done_o (sweep_done)
  );

  kv_cycle_ctr #(.W(TS_W)) u_ctr (
    .clk_i, .rst_ni,
    .cnt_o(cnt)
  );

  // readback verdict and timestamp captured as verification closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ts_q   <= '0;
    end else if (st == ST_VERIFY) begin
      stat_q <= all_zero ? STAT_OK : STAT_BAD;
      ts_q   <= cnt;
    end
  end

  assign prov_ready_o = (st == ST_IDLE);
  assign key_live_o   = (st == ST_LOADED);
  assign busy_o       = (st == ST_ZREGS) | (st == ST_INVAL) |
                        (st == ST_VERIFY) | (st == ST_REPORT);
  assign inv_nowb_o   = (st == ST_INVAL);
  assign rec_valid_o  = (st == ST_REPORT);
  assign rec_o        = {sid, stat_q, ts_q};
  assign sign_slot_o  = ROOT_SLOT;
  assign done_o       = rec_fire;
endmodule

// File: rtl/kv_vault_chk.sv
module kv_vault_chk #(
  parameter int KEY_W = 128,
  parameter int IDX_W = 2,
  parameter int REC_W = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prov_ready_o,
  input logic             busy_o,
  input logic             key_live_o,
  input logic [KEY_W-1:0] key_rd_o,
  input logic             inv_req_o,
  input logic [IDX_W-1:0] inv_slot_o,
  input logic             inv_nowb_o,
  input logic             inv_ack_i,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [REC_W-1:0] rec_o,
  input logic             done_o
);
  AST_RD_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_live_o |-> key_rd_o == '0); // R3
  AST_BUSY_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !prov_ready_o && !key_live_o); // R5
  AST_NOWB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |-> inv_nowb_o && busy_o); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o && !inv_ack_i |=> inv_req_o && $stable(inv_slot_o)); // R6
  AST_NO_REQ_IN_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !inv_req_o && busy_o); // R8
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_o)); // R10
  AST_DONE_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rec_valid_o && rec_ready_i); // R10
  AST_IDLE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> prov_ready_o && !busy_o); // R10
endmodule

bind key_vault_zeroizer kv_vault_chk #(
  .KEY_W(KEY_W), .IDX_W(IDX_W), .REC_W(REC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prov_ready_o(prov_ready_o), .busy_o(busy_o),
  .key_live_o(key_live_o), .key_rd_o(key_rd_o), .inv_req_o(inv_req_o),
  .inv_slot_o(inv_slot_o), .inv_nowb_o(inv_nowb_o), .inv_ack_i(inv_ack_i),
  .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_o(rec_o),
  .done_o(done_o)
);

// File: tb/tb_key_vault_zeroizer.sv
module tb_key_vault_zeroizer;
  localparam int CLK_P = 10;
  localparam int KEY_W = 128;
  localparam int SID_W = 16;
  localparam int N     = 4;
  localparam int IDX_W = 2;
  localparam int REC_W = SID_W + 40;
  localparam logic [7:0] OK_CODE = 8'hA5;

  logic clk = 0, rst_n = 0;
  logic prov_valid_i = 0, done_flag_i = 0, zero_cmd_i = 0, inv_ack_i = 0, rec_ready_i = 0;
  logic [KEY_W-1:0] prov_key_i = '0;
  logic [SID_W-1:0] prov_sid_i = '0;
  logic [N-1:0]     slot_tag_i = '0;
  logic prov_ready_o, busy_o, key_live_o, inv_req_o, inv_nowb_o, rec_valid_o, done_o;
  logic [KEY_W-1:0] key_rd_o;
  logic [IDX_W-1:0] inv_slot_o;
  logic [REC_W-1:0] rec_o;
  logic [3:0]       sign_slot_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cyc;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 32'd1;

  key_vault_zeroizer dut (.clk_i(clk), .rst_ni(rst_n), .*);

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_tagged(input logic [N-1:0] m, input int from);
    for (int i = from; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [KEY_W-1:0] rand_key();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic session(input logic [N-1:0] mask, input bit use_cmd,
                         input int max_dly, input int rdy_dly);
    logic [KEY_W-1:0] k;
    logic [SID_W-1:0] s;
    logic [REC_W-1:0] held;
    logic [31:0] start_cyc;
    int exp_slot, acks, dly, wait_c, tot_dly, guard;
    bit slot_ok;
    k = rand_key();
    s = SID_W'($urandom);
    @(negedge clk);
    chk(prov_ready_o == 1'b1, "R2 ready", prov_ready_o, 1);
    prov_valid_i = 1; prov_key_i = k; prov_sid_i = s;
    @(negedge clk);
    prov_valid_i = 0;
    chk(key_live_o == 1'b1 && key_rd_o == k, "R2 load", key_rd_o, k);
    // R5: refused while loaded
    prov_valid_i = 1; prov_key_i = ~k; prov_sid_i = ~s;
    @(negedge clk);
    prov_valid_i = 0;
    chk(key_rd_o == k && prov_ready_o == 1'b0, "R5 loaded refuse", key_rd_o, k);
    slot_tag_i = mask;
    if (use_cmd) zero_cmd_i = 1; else done_flag_i = 1;
    start_cyc = cyc;
    @(negedge clk);
    zero_cmd_i = 0; done_flag_i = 0;
    slot_tag_i = N'($urandom);
    chk(busy_o == 1'b1 && prov_ready_o == 1'b0, "R4/R5 busy", {busy_o, prov_ready_o}, 2'b10);
    chk(key_rd_o == '0 && key_live_o == 1'b0, "R3 dark", key_rd_o, 0);
    prov_valid_i = 1; prov_key_i = ~k; prov_sid_i = ~s;
    exp_slot = next_tagged(mask, 0);
    acks = 0; tot_dly = 0; wait_c = 0; guard = 0; slot_ok = 1;
    dly = $urandom_range(max_dly, 0);
    while (!rec_valid_o && guard < 400) begin
      inv_ack_i = 0;
      if (inv_req_o) begin
        if (wait_c == dly) begin
          inv_ack_i = 1;
          if (int'(inv_slot_o) != exp_slot || !inv_nowb_o) slot_ok = 0;
          if (int'(inv_slot_o) != exp_slot)
            $display("FAIL R6 slot act=%0d exp=%0d", inv_slot_o, exp_slot);
          acks++; tot_dly += dly;
          exp_slot = (exp_slot < 0) ? -1 : next_tagged(mask, exp_slot + 1);
          wait_c = 0;
          dly = $urandom_range(max_dly, 0);
        end else wait_c++;
      end
      @(negedge clk);
      guard++;
    end
    inv_ack_i = 0;
    prov_valid_i = 0;
    if (!slot_ok) n_bad++;
    n_chk++;
    chk(rec_valid_o == 1'b1 && acks == popc(mask), "R8 acks", acks, popc(mask));
    chk(exp_slot == -1, "R6 all visited", exp_slot, -1);
    chk(cyc - start_cyc == 32'(3 + N + tot_dly), "R7 latency", cyc - start_cyc, 3 + N + tot_dly);
    chk(rec_o == {s, OK_CODE, cyc - 32'd1}, "R9 record", rec_o, {s, OK_CODE, cyc - 32'd1});
    chk(sign_slot_o == 4'd3, "R11 slot", sign_slot_o, 3);
    held = rec_o;
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk(rec_valid_o && rec_o == held && !done_o && !inv_req_o, "R10 hold", rec_o, held);
    end
    rec_ready_i = 1;
    #1;
    chk(done_o == 1'b1, "R10 done", done_o, 1);
    @(negedge clk);
    rec_ready_i = 0;
    chk(prov_ready_o && !busy_o && !rec_valid_o && !key_live_o && key_rd_o == '0,
        "R10/R5 idle", {prov_ready_o, busy_o, rec_valid_o, key_live_o}, 4'b1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(prov_ready_o && !busy_o && !key_live_o && key_rd_o == '0 && !inv_req_o &&
        !rec_valid_o && !done_o, "R1 reset",
        {prov_ready_o, busy_o, key_live_o, inv_req_o, rec_valid_o, done_o}, 6'b100000);
    // R4: strobes in idle are ignored
    zero_cmd_i = 1; done_flag_i = 1;
    @(negedge clk);
    zero_cmd_i = 0; done_flag_i = 0;
    @(negedge clk);
    chk(!busy_o && !rec_valid_o && prov_ready_o, "R4 idle ignore",
        {busy_o, rec_valid_o, prov_ready_o}, 3'b001);
    session(4'b0000, 1'b1, 0, 0);
    session(4'b1111, 1'b0, 0, 1);
    session(4'b1010, 1'b1, 3, 2);
    session(4'b0001, 1'b0, 2, 0);
    session(4'b1000, 1'b1, 1, 3);
    for (int r = 0; r < 20; r++)
      session(N'($urandom), r[0], $urandom_range(4, 0), $urandom_range(3, 0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule